// File: doc/BRIEF.md
# Column Scan Address Sequencer

This block drives the column address bus of a pixel array readout while one row is scanned. After a start request it walks through all 2^ADDR_W columns (256 with the default eight address lines). It holds each address for a programmable dwell time and raises a sample strobe on the final dwell cycle, when the address has had the whole dwell to settle. The scan runs in one of two orders. The first is plain ascending binary. The second is a reflected Gray order, in which any two consecutive addresses differ on a single line, so a slow column decoder never sees several lines move at once. When several lines move together, the old column can deselect before the new one selects, and the shared column output is left floating for a moment.

Because the Gray order does not follow physical position, the block reports with every address the binary number of the column that address selects. Downstream logic uses this number to file each sample. An optional precharge slot of one cycle can be placed ahead of every address load, for decoders that must pre-charge their output nodes before the inputs switch. Scan order, precharge and dwell are captured when a scan starts and stay fixed for that row. When the last column has been sampled the block pulses a done flag and holds the last address until the next start.

Top module: `colscan_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, col_addr and col_index are 0 and pre_stb, sample_stb and row_done are low.
- R2: One scan produces exactly 256 sample strobes, and col_index takes each value 0..255 exactly once at those strobes.
- R3: With gray_mode low at start, the k-th sampled address (k counted from 0) equals k, so the step from 127 to 128 moves all eight lines.
- R4: With gray_mode high at start, the k-th sampled address equals k XOR (k >> 1), and within a row every address change flips exactly one line.
- R5: col_index always equals the unsigned value on col_addr, the physical column the address selects, in both scan orders.
- R6: Each address is held dwell_len cycles (a dwell_len of 0 acts as 1), not counting precharge cycles. sample_stb is high only on the last of those cycles.
- R7: With pre_en high at start, pre_stb is high for one cycle before every address load, the first one included. The address does not move during that cycle and changes on the edge that ends it. pre_stb and sample_stb are never high together.
- R8: row_done is a single-cycle pulse in the cycle after the final sample. Afterwards col_addr stays unchanged and both strobes stay low until the next accepted start.
- R9: A start while a scan is running is ignored. gray_mode, pre_en and dwell_len are sampled only on an accepted start.
- R10: A start that is high in the cycle in which row_done is high is accepted, and the next row follows with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a row scan when idle |
| gray_mode | input | 1 | 1: Gray order, 0: ascending binary order (sampled at start) |
| pre_en | input | 1 | Insert a precharge cycle before each address load (sampled at start) |
| dwell_len | input | DWELL_W | Cycles per column, 0 treated as 1 (sampled at start) |
| col_addr | output | ADDR_W | Column address bus |
| col_index | output | ADDR_W | Binary number of the selected column |
| pre_stb | output | 1 | Precharge slot, address about to change |
| sample_stb | output | 1 | Last dwell cycle of the current address |
| row_done | output | 1 | One-cycle pulse after the last column |

## Verification
Two events can land in the same cycle. The first pair is the row_done pulse and a fresh start. The bench raises start in the very cycle it sees row_done, in both orders and with precharge on. It then requires the new row's first address after exactly one dwell (or one precharge cycle plus one dwell), with all 256 columns present. The second case is the edge where one column's sample strobe ends its dwell and the next address loads, with no precharge. Here a per-cycle monitor counts the dwell run from each address change, so an early or late load shows up as a dwell length mismatch. A start pulse during a running scan, together with toggled mode inputs, must leave the remaining address sequence unchanged.

// File: rtl/colscan_pkg.sv
package colscan_pkg;

    // sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_DWELL = 2'd2
    } scan_state_e;

    // per-row options captured at start
    typedef struct packed {
        logic gray;
        logic pre;
    } scan_mode_t;

    function automatic scan_mode_t make_mode(input logic gray_in, input logic pre_in);
        scan_mode_t m;
        m.gray = gray_in;
        m.pre  = pre_in;
        return m;
    endfunction

endpackage

// File: rtl/colscan_dwell.sv
module colscan_dwell #(
    parameter int DWELL_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [DWELL_W-1:0] lim,
    output logic               last
);
    logic [DWELL_W-1:0] cnt_q;

    assign last = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/colscan_fsm.sv
module colscan_fsm
    import colscan_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DWELL_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               gray_in,
    input  logic               pre_in,
    input  logic [DWELL_W-1:0] dwell_in,
    input  logic               last,
    output scan_state_e        state,
    output scan_mode_t         mode,
    output logic [DWELL_W-1:0] lim,
    output logic               load,
    output logic               load_gray,
    output logic [ADDR_W-1:0]  step_nx,
    output logic               row_done
);
    logic [ADDR_W-1:0] step_q;
    logic              final_col;

    assign final_col = (step_q == {ADDR_W{1'b1}});
    assign step_nx   = (state == ST_IDLE) ? '0 : step_q + 1'b1;
    assign load_gray = (state == ST_IDLE) ? gray_in : mode.gray;

    always_comb begin
        load = 1'b0;
        case (state)
            ST_IDLE:  load = start && !pre_in;
            ST_PRE:   load = 1'b1;
            ST_DWELL: load = last && !final_col && !mode.pre;
            default:  load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode     <= make_mode(1'b0, 1'b0);
            lim      <= '0;
            step_q   <= '0;
            row_done <= 1'b0;
        end else begin
            row_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode <= make_mode(gray_in, pre_in);
                        lim  <= (dwell_in == '0) ? '0 : dwell_in - 1'b1;
                        if (pre_in) begin
                            state  <= ST_PRE;
                            step_q <= {ADDR_W{1'b1}};
                        end else begin
                            state  <= ST_DWELL;
                            step_q <= step_nx;
                        end
                    end
                end
                ST_PRE: begin
                    state  <= ST_DWELL;
                    step_q <= step_nx;
                end
                ST_DWELL: begin
                    if (last) begin
                        if (final_col) begin
                            state    <= ST_IDLE;
                            row_done <= 1'b1;
                        end else if (mode.pre) begin
                            state <= ST_PRE;
                        end else begin
                            step_q <= step_nx;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/colscan_addr.sv
module colscan_addr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              gray,
    input  logic [ADDR_W-1:0] step_nx,
    output logic [ADDR_W-1:0] col_addr,
    output logic [ADDR_W-1:0] col_index
);
    logic [ADDR_W-1:0] flip;
    logic [ADDR_W-1:0] gcode;

    // bit to toggle when the Gray register advances to step_nx
    // gcode: reflected code of step_nx for the index path
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bits
        if (i == 0) begin : g_lsb
            assign flip[i] = step_nx[i];
        end else begin : g_upper
            assign flip[i] = step_nx[i] && (step_nx[i-1:0] == '0);
        end
        if (i == ADDR_W - 1) begin : g_top
            assign gcode[i] = step_nx[i];
        end else begin : g_low
            assign gcode[i] = step_nx[i] ^ step_nx[i+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_addr  <= '0;
            col_index <= '0;
        end else if (load) begin
            if (!gray) begin
                col_addr  <= step_nx;
                col_index <= step_nx;
            end else begin
                col_addr  <= (step_nx == '0) ? '0 : (col_addr ^ flip);
                col_index <= gcode;
            end
        end
    end
endmodule

// File: rtl/colscan_seq.sv
module colscan_seq
    import colscan_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DWELL_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               gray_mode,
    input  logic               pre_en,
    input  logic [DWELL_W-1:0] dwell_len,
    output logic [ADDR_W-1:0]  col_addr,
    output logic [ADDR_W-1:0]  col_index,
    output logic               pre_stb,
    output logic               sample_stb,
    output logic               row_done
);
    scan_state_e        state;
    scan_mode_t         mode_q;
    logic [DWELL_W-1:0] lim;
    logic               last;
    logic               load;
    logic               load_gray;
    logic [ADDR_W-1:0]  step_nx;
    logic               busy;
    logic               cfg_gray;
    logic               cfg_pre;

    assign busy       = (state != ST_IDLE);
    assign cfg_gray   = mode_q.gray;
    assign cfg_pre    = mode_q.pre;
    assign pre_stb    = (state == ST_PRE);
    assign sample_stb = last;

    colscan_fsm #(.ADDR_W(ADDR_W), .DWELL_W(DWELL_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .gray_in   (gray_mode),
        .pre_in    (pre_en),
        .dwell_in  (dwell_len),
        .last      (last),
        .state     (state),
        .mode      (mode_q),
        .lim       (lim),
        .load      (load),
        .load_gray (load_gray),
        .step_nx   (step_nx),
        .row_done  (row_done)
    );

    colscan_dwell #(.DWELL_W(DWELL_W)) u_dwell (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_DWELL),
        .lim  (lim),
        .last (last)
    );

    colscan_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .gray      (load_gray),
        .step_nx   (step_nx),
        .col_addr  (col_addr),
        .col_index (col_index)
    );
endmodule

// File: rtl/colscan_seq_chk.sv
module colscan_seq_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              cfg_gray,
    input logic              cfg_pre,
    input logic [ADDR_W-1:0] col_addr,
    input logic [ADDR_W-1:0] col_index,
    input logic              pre_stb,
    input logic              sample_stb,
    input logic              row_done
);
    assert_index_tracks_addr_R5: assert property (@(posedge clk) disable iff (rst)
        col_index == col_addr);

    assert_gray_single_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && cfg_gray && (col_addr != $past(col_addr)))
        |-> ($countones(col_addr ^ $past(col_addr)) == 1));

    assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(pre_stb && sample_stb));

    assert_change_after_pre_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_pre && (col_addr != $past(col_addr))) |-> $past(pre_stb));

    assert_done_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        row_done |=> !row_done);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(col_addr));

    assert_sample_in_scan_R6: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> busy);
endmodule

bind colscan_seq colscan_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .cfg_gray   (cfg_gray),
    .cfg_pre    (cfg_pre),
    .col_addr   (col_addr),
    .col_index  (col_index),
    .pre_stb    (pre_stb),
    .sample_stb (sample_stb),
    .row_done   (row_done)
);

// File: tb/colscan_seq_tb.sv
`timescale 1ns/1ps
module colscan_seq_tb;
    localparam int AW = 8;
    localparam int DW = 4;
    localparam int NCOL = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          gray_mode = 1'b0;
    logic          pre_en = 1'b0;
    logic [DW-1:0] dwell_len = '0;
    logic [AW-1:0] col_addr;
    logic [AW-1:0] col_index;
    logic          pre_stb;
    logic          sample_stb;
    logic          row_done;

    always #4 clk = ~clk;

    colscan_seq #(.ADDR_W(AW), .DWELL_W(DW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .gray_mode(gray_mode),
        .pre_en(pre_en), .dwell_len(dwell_len), .col_addr(col_addr),
        .col_index(col_index), .pre_stb(pre_stb), .sample_stb(sample_stb),
        .row_done(row_done)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    bit            mon_on = 1'b0;
    bit            cfg_gray, cfg_pre;
    int            cfg_d;
    int            k, run;
    logic [AW-1:0] last_addr;
    bit            prev_pre;
    bit            seen [NCOL];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
            finish_run();
        end
    end

    // cycle monitor: address order, dwell, precharge and completeness
    always @(negedge clk) begin
        if (mon_on) begin
            int expv;
            if (pre_stb) begin
                chk(col_addr == last_addr, "R7", "address moved during precharge",
                    int'(col_addr), int'(last_addr));
                chk(cfg_pre, "R7", "precharge while disabled", int'(pre_stb), 0);
                chk(!sample_stb, "R7", "sample with precharge", int'(sample_stb), 0);
                run = 0;
            end else if (col_addr != last_addr) begin
                if (cfg_pre)
                    chk(prev_pre, "R7", "address change without precharge",
                        int'(prev_pre), 1);
                if (cfg_gray && k > 0)
                    chk($countones(col_addr ^ last_addr) == 1, "R4", "lines toggled",
                        $countones(col_addr ^ last_addr), 1);
                run = 1;
            end else begin
                run++;
            end
            if (sample_stb) begin
                expv = cfg_gray ? (k ^ (k >> 1)) : k;
                chk(int'(col_addr) == expv, cfg_gray ? "R4" : "R3", "address order",
                    int'(col_addr), expv);
                chk(int'(col_index) == expv, "R5", "column index", int'(col_index), expv);
                chk(run == cfg_d, "R6", "dwell length", run, cfg_d);
                chk(!seen[col_index], "R2", "repeated column", int'(col_index), -1);
                seen[col_index] = 1'b1;
                k++;
            end
            if (row_done)
                chk(k == NCOL, "R2", "samples before row_done", k, NCOL);
            last_addr = col_addr;
            prev_pre  = pre_stb;
        end
    end

    // launch one row; immediate=1 starts in the current cycle (row_done cycle)
    task automatic run_row(input bit gray, input bit pre, input int d_in,
                           input bit immediate, input bit poke, input string req);
        int n;
        if (!immediate) @(negedge clk);
        #1;
        cfg_gray = gray; cfg_pre = pre;
        cfg_d = (d_in == 0) ? 1 : d_in;
        k = 0; run = 0;
        foreach (seen[i]) seen[i] = 1'b0;
        last_addr = col_addr; prev_pre = 1'b0; mon_on = 1'b1;
        gray_mode = gray; pre_en = pre; dwell_len = DW'(d_in);
        start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
        n = 0;
        while (!row_done) begin
            @(negedge clk);
            n++;
            if (poke && !row_done && (n == 20 || n == 300)) begin
                #1; start = 1'b1; gray_mode = ~gray; pre_en = ~pre;
                dwell_len = DW'(d_in + 2);
            end else if (poke) begin
                #1; start = 1'b0;
            end
        end
        chk(k == NCOL, req, "row completed with all columns", k, NCOL);
    endtask

    task automatic hold_check();
        logic [AW-1:0] held;
        held = col_addr;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!row_done, "R8", "row_done width", int'(row_done), 0);
            chk(col_addr == held, "R8", "address hold after row", int'(col_addr), int'(held));
            chk(!pre_stb && !sample_stb, "R8", "strobes idle",
                int'(pre_stb) + int'(sample_stb), 0);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(col_addr == '0 && col_index == '0, "R1", "address in reset",
            int'(col_addr), 0);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(col_addr == '0, "R1", "address after reset", int'(col_addr), 0);
        chk(col_index == '0, "R1", "index after reset", int'(col_index), 0);
        chk(!pre_stb && !sample_stb && !row_done, "R1", "flags after reset",
            int'(pre_stb) + int'(sample_stb) + int'(row_done), 0);
    endtask

    initial begin
        test_reset();
        run_row(1'b0, 1'b0, 1, 1'b0, 1'b0, "R3");   // binary, no precharge
        hold_check();
        run_row(1'b1, 1'b0, 3, 1'b0, 1'b0, "R4");   // Gray, dwell 3
        hold_check();
        run_row(1'b1, 1'b1, 2, 1'b0, 1'b0, "R7");   // Gray with precharge
        run_row(1'b1, 1'b1, 2, 1'b1, 1'b0, "R10");  // back-to-back in done cycle
        run_row(1'b0, 1'b0, 2, 1'b1, 1'b0, "R10");  // back-to-back, order switch
        hold_check();
        run_row(1'b0, 1'b1, 1, 1'b0, 1'b1, "R9");   // starts while busy ignored
        hold_check();
        run_row(1'b0, 1'b0, 0, 1'b0, 1'b0, "R6");   // dwell 0 acts as 1
        hold_check();
        finish_run();
    end
endmodule